// File: doc/BRIEF.md
# System Tick Down-Counter Timer

A periodic down-counter for the heartbeat interrupt of a processor subsystem. Software sets a reload value and enables the timer through a small word-addressed register port. The counter then steps down on every core clock cycle, or only on cycles where a reference tick enable is high. When the count has sat at zero for one counting tick, the timer expires. It sets a sticky flag, can pulse an interrupt request and starts the next period from the reload value.

A reload value of zero makes the timer run a single period and then switch itself off. Software can restart the period at any moment by writing anything to the current-value register. Reading the control register reports the flag and clears it. A fixed calibration word is also readable. Reads are combinational on the cycle the request is presented; writes and read side effects take effect at the next rising clock edge.

Top module: `systick_timer`

## Requirements
- R1: After reset, control reads 0, reload reads 0, current reads 0 and irq_o is low. The registers sit at byte offsets 0x10 (control), 0x14 (reload), 0x18 (current value) and 0x1C (calibration).
- R2: A control write changes only bits 2:0. Bit 0 is run, bit 1 is interrupt enable, bit 2 selects the source (1 = every core clock, 0 = ref_tick_i). All other bits, including the flag at bit 16, ignore write data.
- R3: With the core clock source, expiries are reload+1 clock cycles apart, and the first comes reload+1 cycles after the enabling write. irq_o rises in the cycle after the expiring tick and lasts exactly one cycle.
- R4: Each expiry sets control bit 16. A control read returns the bit and clears it.
- R5: irq_o pulses on expiry only when control bit 1 is set; the flag is set either way.
- R6: If reload is zero at expiry, control bit 0 clears and counting stops.
- R7: The current-value register reads 0 while bit 0 is clear. While counting, it reads the live count, which reaches 0 one tick before the expiring tick.
- R8: A write of any data to the current-value register loads the reload value into the count and clears the flag.
- R9: The calibration register reads the constant CAL_VAL (default 10000).
- R10: With the reference source selected, the count moves only on cycles where ref_tick_i is high.
- R11: Changing the source bit while the timer runs restarts the count from the reload value.
- R12: When a control read falls in the same cycle as an expiry, the read returns the old flag and the flag ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid while req_i is high with we_i low |
| ref_tick_i | input | 1 | Reference tick enable, synchronous to clk_i |
| irq_o | output | 1 | One-cycle interrupt request pulse |

## Verification
An expiry sets the flag while a control read clears it, and both can fall on the same edge. The bench times a control read to land on the cycle in which the count sits at zero under the core clock. That read must report the flag clear, and a read straight after it must report the flag set. A write to the current-value register against an expiry is also covered, by a property: it must leave the flag clear.

// File: rtl/systick_pkg.sv
package systick_pkg;
  localparam int unsigned BUS_DW = 32;
  localparam int unsigned REG_AW = 8;

  localparam logic [REG_AW-1:0] OFS_CTRL = 8'h10;
  localparam logic [REG_AW-1:0] OFS_LOAD = 8'h14;
  localparam logic [REG_AW-1:0] OFS_CUR  = 8'h18;
  localparam logic [REG_AW-1:0] OFS_CAL  = 8'h1C;

  localparam int unsigned BIT_RUN   = 0;
  localparam int unsigned BIT_IRQEN = 1;
  localparam int unsigned BIT_CORE  = 2;
  localparam int unsigned BIT_FLAG  = 16;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_LOAD,
    SEL_CUR,
    SEL_CAL
  } reg_sel_e;

  typedef struct packed {
    logic core_src;
    logic irq_en;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/systick_decode.sv
module systick_decode
  import systick_pkg::*;
(
  input  logic              req_i,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  output reg_sel_e          sel_o,
  output logic              wr_o,
  output logic              rd_o
);
  always_comb begin
    unique case (addr_i)
      OFS_CTRL: sel_o = SEL_CTRL;
      OFS_LOAD: sel_o = SEL_LOAD;
      OFS_CUR:  sel_o = SEL_CUR;
      OFS_CAL:  sel_o = SEL_CAL;
      default:  sel_o = SEL_NONE;
    endcase
  end

  assign wr_o = req_i &  we_i & (sel_o != SEL_NONE);
  assign rd_o = req_i & ~we_i & (sel_o != SEL_NONE);
endmodule

// File: rtl/systick_regs.sv
module systick_regs
  import systick_pkg::*;
#(
  parameter int unsigned CNT_W   = 24,
  parameter int unsigned CAL_VAL = 10000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  reg_sel_e          sel_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [BUS_DW-1:0] wdata_i,
  input  logic              expire_i,
  input  logic [CNT_W-1:0]  cur_i,
  output ctrl_t             ctrl_o,
  output logic [CNT_W-1:0]  reload_o,
  output logic              flag_o,
  output logic              load_o,
  output logic [BUS_DW-1:0] rdata_o
);
  ctrl_t            ctrl_q, ctrl_wr;
  logic [CNT_W-1:0] reload_q;
  logic             flag_q;
  logic             wr_ctrl, wr_load, wr_cur, rd_ctrl, stop;

  assign wr_ctrl = wr_i & (sel_i == SEL_CTRL);
  assign wr_load = wr_i & (sel_i == SEL_LOAD);
  assign wr_cur  = wr_i & (sel_i == SEL_CUR);
  assign rd_ctrl = rd_i & (sel_i == SEL_CTRL);

  assign ctrl_wr.run      = wdata_i[BIT_RUN];
  assign ctrl_wr.irq_en   = wdata_i[BIT_IRQEN];
  assign ctrl_wr.core_src = wdata_i[BIT_CORE];

  // restart on: current write, 0->1 run, source change while running
  assign load_o = wr_cur
                | (wr_ctrl & ~ctrl_q.run & ctrl_wr.run)
                | (wr_ctrl & ctrl_q.run & ctrl_wr.run & (ctrl_wr.core_src != ctrl_q.core_src));

  assign stop = expire_i & (reload_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_q <= ctrl_wr;
    end else if (stop) begin
      ctrl_q.run <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      reload_q <= '0;
    else if (wr_load) reload_q <= wdata_i[CNT_W-1:0];
  end

  // expiry wins over read-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                flag_q <= 1'b0;
    else if (expire_i)          flag_q <= 1'b1;
    else if (rd_ctrl || wr_cur) flag_q <= 1'b0;
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      unique case (sel_i)
        SEL_CTRL: begin
          rdata_o[BIT_RUN]   = ctrl_q.run;
          rdata_o[BIT_IRQEN] = ctrl_q.irq_en;
          rdata_o[BIT_CORE]  = ctrl_q.core_src;
          rdata_o[BIT_FLAG]  = flag_q;
        end
        SEL_LOAD: rdata_o[CNT_W-1:0] = reload_q;
        SEL_CUR:  rdata_o[CNT_W-1:0] = ctrl_q.run ? cur_i : '0;
        SEL_CAL:  rdata_o = BUS_DW'(CAL_VAL);
        default:  rdata_o = '0;
      endcase
    end
  end

  assign ctrl_o   = ctrl_q;
  assign reload_o = reload_q;
  assign flag_o   = flag_q;
endmodule

// File: rtl/systick_counter.sv
module systick_counter #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             core_src_i,
  input  logic             ref_tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cur_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cur_q;
  logic             tick;

  assign tick     = core_src_i ? 1'b1 : ref_tick_i;
  assign expire_o = run_i & tick & (cur_q == '0) & ~load_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= '0;
    end else if (load_i) begin
      cur_q <= reload_i;
    end else if (run_i && tick) begin
      cur_q <= (cur_q == '0) ? reload_i : cur_q - 1'b1;
    end
  end

  assign cur_o = cur_q;
endmodule

// File: rtl/systick_timer.sv
module systick_timer
  import systick_pkg::*;
#(
  parameter int unsigned CNT_W   = 24,
  parameter int unsigned CAL_VAL = 10000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [BUS_DW-1:0] wdata_i,
  output logic [BUS_DW-1:0] rdata_o,
  input  logic              ref_tick_i,
  output logic              irq_o
);
  reg_sel_e         sel;
  logic             wr, rd, load, expire, flag, irq_q;
  ctrl_t            ctrl;
  logic [CNT_W-1:0] reload_val, cur_val;
  logic             ctrl_run;

  systick_decode u_decode (
    .req_i  (req_i),
    .we_i   (we_i),
    .addr_i (addr_i),
    .sel_o  (sel),
    .wr_o   (wr),
    .rd_o   (rd)
  );

  systick_regs #(.CNT_W(CNT_W), .CAL_VAL(CAL_VAL)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sel_i    (sel),
    .wr_i     (wr),
    .rd_i     (rd),
    .wdata_i  (wdata_i),
    .expire_i (expire),
    .cur_i    (cur_val),
    .ctrl_o   (ctrl),
    .reload_o (reload_val),
    .flag_o   (flag),
    .load_o   (load),
    .rdata_o  (rdata_o)
  );

  systick_counter #(.CNT_W(CNT_W)) u_counter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (ctrl.run),
    .core_src_i (ctrl.core_src),
    .ref_tick_i (ref_tick_i),
    .load_i     (load),
    .reload_i   (reload_val),
    .cur_o      (cur_val),
    .expire_o   (expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= expire & ctrl.irq_en;
  end

  assign ctrl_run = ctrl.run;
  assign irq_o    = irq_q;
endmodule

// File: rtl/systick_timer_chk.sv
module systick_timer_chk
  import systick_pkg::*;
#(
  parameter int unsigned CNT_W = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [REG_AW-1:0] addr_i,
  input logic              irq_o,
  input logic              ctrl_run,
  input logic              flag,
  input logic              expire,
  input logic [CNT_W-1:0]  reload_val,
  input logic [CNT_W-1:0]  cur_val
);
  a_r3_irq_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  a_r4_flag_with_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> flag);

  a_r6_zero_reload_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire && reload_val == '0 && !(req_i && we_i && addr_i == OFS_CTRL)) |=> !ctrl_run);

  a_r7_idle_count_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_run && !(req_i && we_i)) |=> $stable(cur_val));

  a_r8_cur_write_clears_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == OFS_CUR) |=> !flag);
endmodule

bind systick_timer systick_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .we_i       (we_i),
  .addr_i     (addr_i),
  .irq_o      (irq_o),
  .ctrl_run   (ctrl_run),
  .flag       (flag),
  .expire     (expire),
  .reload_val (reload_val),
  .cur_val    (cur_val)
);

// File: tb/systick_timer_test.sv
module systick_timer_test;
  localparam logic [7:0] A_CTRL = 8'h10, A_LOAD = 8'h14, A_CUR = 8'h18, A_CAL = 8'h1C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, ref_tick = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        irq;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  systick_timer uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .ref_tick_i(ref_tick), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(posedge clk); @(negedge clk);
    req = 1'b0;
  endtask

  task automatic wait_irq(input int max, output int n);
    n = 0;
    forever begin
      @(negedge clk); n++;
      if (irq === 1'b1 || n > max) break;
    end
  endtask

  task automatic ref_pulse(input int k);
    for (int i = 0; i < k; i++) begin
      ref_tick = 1'b1; @(negedge clk);
      ref_tick = 1'b0; @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int n, hits;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state, R9 calibration
    bus_rd(A_CTRL, v); chk("R1 ctrl", v, 32'h0);
    bus_rd(A_LOAD, v); chk("R1 reload", v, 32'h0);
    bus_rd(A_CUR, v);  chk("R1 cur", v, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    bus_rd(A_CAL, v);  chk("R9 calib", v, 32'd10000);

    // R2 only bits 2:0 writable
    bus_wr(A_CTRL, 32'hFFFF_FFF8); bus_rd(A_CTRL, v); chk("R2 upper bits", v, 32'h0);
    bus_wr(A_CTRL, 32'h0001_0000); bus_rd(A_CTRL, v); chk("R2 flag not writable", v, 32'h0);

    // R3/R4 period sweep, core clock with interrupt
    for (int r = 1; r <= 8; r++) begin
      bus_wr(A_LOAD, r);
      bus_wr(A_CTRL, 32'h7);
      wait_irq(40, n); chk($sformatf("R3 first period r=%0d", r), n, r + 1);
      wait_irq(40, n); chk($sformatf("R3 second period r=%0d", r), n, r + 1);
      @(negedge clk); chk("R3 irq single cycle", {31'b0, irq}, 32'h0);
      bus_wr(A_CTRL, 32'h0);
      bus_rd(A_CTRL, v); chk("R4 flag read", v, 32'h0001_0000);
      bus_rd(A_CTRL, v); chk("R4 flag cleared", v, 32'h0);
    end

    // R7 disabled reads zero
    bus_wr(A_LOAD, 3); bus_rd(A_CUR, v); chk("R7 disabled cur", v, 32'h0);

    // R6 zero reload
    bus_wr(A_LOAD, 0); bus_wr(A_CTRL, 32'h7);
    wait_irq(10, n); chk("R6 single period", n, 1);
    bus_rd(A_CTRL, v); chk("R6 run cleared", v, 32'h0001_0006);
    hits = 0;
    for (int i = 0; i < 10; i++) begin @(negedge clk); if (irq) hits++; end
    chk("R6 no further irq", hits, 0);

    // R5 no irq without enable, flag still set
    bus_wr(A_LOAD, 3); bus_wr(A_CTRL, 32'h5);
    hits = 0;
    for (int i = 0; i < 12; i++) begin @(negedge clk); if (irq) hits++; end
    chk("R5 irq masked", hits, 0);
    bus_rd(A_CTRL, v); chk("R5 flag set", v, 32'h0001_0005);
    bus_wr(A_CTRL, 32'h0);

    // R11 source change restarts, R10 reference tick
    bus_wr(A_LOAD, 9); bus_wr(A_CTRL, 32'h5);
    repeat (3) @(negedge clk);
    bus_wr(A_CTRL, 32'h1);
    bus_rd(A_CUR, v); chk("R11 restart on source change", v, 32'd9);
    repeat (4) @(negedge clk);
    bus_rd(A_CUR, v); chk("R10 frozen without tick", v, 32'd9);
    ref_pulse(1); bus_rd(A_CUR, v); chk("R10 one tick", v, 32'd8);
    ref_pulse(8); bus_rd(A_CUR, v); chk("R7 reads zero at end", v, 32'd0);
    bus_rd(A_CTRL, v); chk("R10 no expiry yet", v, 32'h1);
    ref_pulse(1); bus_rd(A_CUR, v); chk("R10 wrap to reload", v, 32'd9);
    bus_rd(A_CTRL, v); chk("R10 expiry flag", v, 32'h0001_0001);

    // R8 current write reloads and clears flag
    ref_pulse(10);
    bus_wr(A_LOAD, 5);
    bus_wr(A_CUR, 32'hDEAD);
    bus_rd(A_CUR, v);  chk("R8 reload on write", v, 32'd5);
    bus_rd(A_CTRL, v); chk("R8 flag cleared", v, 32'h1);
    bus_wr(A_CTRL, 32'h0);

    // R12 read-clear collides with expiry
    bus_wr(A_LOAD, 4); bus_wr(A_CTRL, 32'h5);
    repeat (4) @(negedge clk);
    bus_rd(A_CTRL, v); chk("R12 read in expiry cycle", v, 32'h5);
    bus_rd(A_CTRL, v); chk("R12 flag survives", v, 32'h0001_0005);
    bus_wr(A_CTRL, 32'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule